// File: doc/BRIEF.md
# One-hot Sum Stage with Merged Flow Registration

This block is a single stage of a clockless-style dual-phase pipeline, modelled so that it can be simulated and synthesized with a clock. It takes two one-hot operands and produces their one-hot sum. Operand A has `A_RAILS` rails and operand B has `B_RAILS` rails. The sum has `A_RAILS + B_RAILS - 1` rails. With the defaults, a 1-of-2 value plus a 1-of-3 value gives a 1-of-4 result.

There is no separate latch rank. The close input from the next stage is folded into every product term of the sum function. Each sum rail is a hysteresis element that remembers its last value. The stage therefore passes a data wavefront only while close asks for data. It passes a null wavefront only while close asks for null. At all other times it holds what it has.

A completion output reports whether the output wavefront is currently data or null. It serves as the acknowledge sent back toward the producers. The next stage's completion, inverted, serves as this stage's close input.

Top module: `ncl_sum_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every sum rail and `done_o` are 0 after that edge.
- R2: A rail value of 1 means data and 0 means null. Operand A rail `i` stands for the value `i`, and operand B rail `j` stands for `j`. With the defaults, sum rail 0 is produced by A0 with B0. Sum rail 1 is produced by A0 with B1, or by A1 with B0. Sum rail 2 is produced by A0 with B2, or by A1 with B1. Sum rail 3 is produced by A1 with B2.
- R3: The clock edge after both operands carry data while `close_i` is 1, exactly the sum rail `i + j` is 1.
- R4: While `close_i` stays 1, a data output is held unchanged, even after the operands return to null.
- R5: When `close_i` is 0 and both operands are null, every sum rail is 0 after the next clock edge.
- R6: While `close_i` stays 0, a null output stays null, even when data is present on the operands.
- R7: `done_o` is 1 exactly when some sum rail is 1, in the same cycle. It can rise only after an edge at which `close_i` was 1, and fall only after an edge at which `close_i` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation clock for the hysteresis rails |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | A_RAILS | One-hot operand A (all zero = null) |
| op_b | input | B_RAILS | One-hot operand B (all zero = null) |
| close_i | input | 1 | 1 lets data through, 0 lets null through |
| sum_o | output | A_RAILS+B_RAILS-1 | One-hot sum rails |
| done_o | output | 1 | Completion: 1 while the output is data |

## Verification
The bench builds the stage with its defaults of two and three operand rails. This lets it drive all six operand pairings, each twice, through a full four-phase cycle. The producers and consumer are scripted to hold each phase for two cycles. As a result, the hold-data case (operands already null, close still 1) and the hold-null case (data waiting, close still 0) are each observed for several edges per pairing.

// File: rtl/ncl_pkg.sv
// Package: shared rail encoding and default sizes for the one-hot sum stage.
// Assumes: a rail value of 1 is data and 0 is null.
package ncl_pkg;
    typedef enum logic {
        RAIL_NULL = 1'b0,
        RAIL_DATA = 1'b1
    } rail_t;

    localparam int DEF_A_RAILS = 2;
    localparam int DEF_B_RAILS = 3;
endpackage

// File: rtl/ncl_rail_term.sv
// Module: ncl_rail_term
// Does: computes, for one sum rail, the OR of all operand-pair products whose
//       values add up to RAIL_IDX, and whether any rail feeding those products
//       is still data.
// Assumes: operands are one-hot or all-zero; purely combinational.
module ncl_rail_term #(
    parameter int A_RAILS  = 2,
    parameter int B_RAILS  = 3,
    parameter int RAIL_IDX = 0
) (
    input  logic [A_RAILS-1:0] op_a,
    input  logic [B_RAILS-1:0] op_b,
    output logic               term_o,
    output logic               busy_o
);
    // Sum-of-products for this rail, and the activity of its feeding rails.
    always_comb begin
        term_o = 1'b0;
        busy_o = 1'b0;
        for (int i = 0; i < A_RAILS; i++) begin
            for (int j = 0; j < B_RAILS; j++) begin
                if (i + j == RAIL_IDX) begin
                    term_o = term_o | (op_a[i] & op_b[j]);
                    busy_o = busy_o | op_a[i] | op_b[j];
                end
            end
        end
    end
endmodule

// File: rtl/ncl_hyst_rail.sv
// Module: ncl_hyst_rail
// Does: one state-holding output rail. It sets when its product term (with
//       close) is true and clears when close is null and none of its feeding
//       rails is data; otherwise it keeps its value.
// Assumes: synchronous active-low reset; evaluation once per clock edge.
module ncl_hyst_rail (
    input  logic clk,
    input  logic rst_n,
    input  logic close_i,
    input  logic term_i,
    input  logic busy_i,
    output logic rail_q
);
    import ncl_pkg::*;

    // Hysteresis update: set, clear or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_q <= RAIL_NULL;
        end else if (close_i && term_i) begin
            rail_q <= RAIL_DATA;
        end else if (!close_i && !busy_i) begin
            rail_q <= RAIL_NULL;
        end
    end

    AST_RAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && term_i) |=> rail_q) else $error("rail did not set"); // R3
    AST_RAIL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && rail_q) |=> rail_q) else $error("data not held"); // R4
    AST_RAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!close_i && !busy_i) |=> !rail_q) else $error("rail did not clear"); // R5
    AST_RAIL_HOLDS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!close_i && !rail_q) |=> !rail_q) else $error("null not held"); // R6
endmodule

// File: rtl/ncl_completion.sv
// Module: ncl_completion
// Does: completeness detection over a one-hot rail group: data once any rail
//       is data, null once all rails are null.
// Assumes: the rails are state-holding, so the OR is glitch-free per cycle.
module ncl_completion #(
    parameter int RAILS = 4
) (
    input  logic [RAILS-1:0] rails_i,
    output logic             done_o
);
    // Completion is the OR of the rails.
    always_comb begin
        done_o = |rails_i;
    end
endmodule

// File: rtl/ncl_sum_stage.sv
// Module: ncl_sum_stage
// Does: adds a one-hot A_RAILS operand to a one-hot B_RAILS operand. Flow
//       registration is merged into the sum function through close_i, and
//       completion is reported on done_o.
// Assumes: the producers send complete wavefronts and alternate data with
//          null; close_i is the inverse of the next stage's completion.
module ncl_sum_stage #(
    parameter int A_RAILS = ncl_pkg::DEF_A_RAILS,
    parameter int B_RAILS = ncl_pkg::DEF_B_RAILS,
    localparam int S_RAILS = A_RAILS + B_RAILS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [A_RAILS-1:0] op_a,
    input  logic [B_RAILS-1:0] op_b,
    input  logic               close_i,
    output logic [S_RAILS-1:0] sum_o,
    output logic               done_o
);
    logic [S_RAILS-1:0] term_w;
    logic [S_RAILS-1:0] busy_w;

    // One term generator and one hysteresis rail per sum value.
    for (genvar k = 0; k < S_RAILS; k++) begin : g_rail
        ncl_rail_term #(
            .A_RAILS (A_RAILS),
            .B_RAILS (B_RAILS),
            .RAIL_IDX(k)
        ) u_term (
            .op_a  (op_a),
            .op_b  (op_b),
            .term_o(term_w[k]),
            .busy_o(busy_w[k])
        );

        ncl_hyst_rail u_rail (
            .clk    (clk),
            .rst_n  (rst_n),
            .close_i(close_i),
            .term_i (term_w[k]),
            .busy_i (busy_w[k]),
            .rail_q (sum_o[k])
        );
    end

    ncl_completion #(.RAILS(S_RAILS)) u_done (
        .rails_i(sum_o),
        .done_o (done_o)
    );

    AST_RESET_NULL: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && !done_o)) else $error("reset not null"); // R1
    AST_DONE_RISE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(close_i)) else $error("done rose while close null"); // R7
    AST_DONE_FALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> !$past(close_i)) else $error("done fell while close data"); // R7
endmodule

// File: tb/ncl_sum_stage_bench.sv
module ncl_sum_stage_bench;
    localparam int A = 2;
    localparam int B = 3;
    localparam int S = A + B - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [A-1:0] op_a;
    logic [B-1:0] op_b;
    logic         close_en;
    logic [S-1:0] sum;
    logic         done;

    int checks = 0;
    int errors = 0;
    int exp_code = -1;  // -1 = null, otherwise expected sum value

    always #5 clk = ~clk;

    ncl_sum_stage u_ncl_sum_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .close_i(close_en),
        .sum_o  (sum),
        .done_o (done)
    );

    // Value carried by a one-hot group; -1 when null or malformed.
    function automatic int value_of(input logic [7:0] v);
        int n = 0;
        int pos = -1;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) begin
                n++;
                pos = i;
            end
        end
        return (n == 1) ? pos : -1;
    endfunction

    function automatic logic [S-1:0] vec_of(input int code);
        return (code < 0) ? '0 : S'(1 << code);
    endfunction

    // Reference model: whole-wavefront behaviour of the stage.
    always @(posedge clk) begin : model
        int av;
        int bv;
        av = value_of(8'(op_a));
        bv = value_of(8'(op_b));
        if (!rst_n) exp_code = -1;
        else if (close_en && av >= 0 && bv >= 0) exp_code = av + bv;
        else if (!close_en && op_a == '0 && op_b == '0) exp_code = -1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: the per-cycle comparison against the model, away from the edge.
    task automatic tick();
        @(negedge clk);
        chk("R2 sum vs model", 32'(sum), 32'(vec_of(exp_code)));
        chk("R7 done vs model", 32'(done), 32'(exp_code >= 0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0;
        op_a = '0;
        op_b = '0;
        close_en = 1'b1;
        repeat (3) tick();
        chk("R1 reset sum", 32'(sum), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int i = 0; i < A; i++) begin
                for (int j = 0; j < B; j++) begin
                    // Producers present data; close may still be null.
                    op_a = A'(1 << i);
                    op_b = B'(1 << j);
                    tick();
                    tick();
                    if (!close_en) begin
                        chk("R6 null held with data waiting", 32'(sum), 32'd0);
                        close_en = 1'b1;
                    end
                    tick();
                    chk("R3 data passed", 32'(sum), 32'(1 << (i + j)));
                    chk("R7 done data", 32'(done), 32'd1);
                    // Producers go null while the consumer keeps close at data.
                    op_a = '0;
                    op_b = '0;
                    tick();
                    tick();
                    chk("R4 data held after inputs null", 32'(sum), 32'(1 << (i + j)));
                    close_en = 1'b0;
                    tick();
                    chk("R5 null passed", 32'(sum), 32'd0);
                    chk("R7 done null", 32'(done), 32'd0);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule